// File: doc/BRIEF.md
# Count-Tick Prescaler and Pin Glitch Filter

This block generates the increment enable of a compare timer's counter. In time-counting mode it takes one of several clock-enable strobes and divides it by a programmable power of two. In pulse-counting mode it selects one of several input pins and synchronises it. It then applies a polarity and either passes each active edge straight through or first requires the new level to stay put for a programmable number of strobes of the selected filter clock. A bypass bit skips the divider or the filter. Everything runs on a single system clock. The clock sources arrive as one-cycle enable strobes, and the output is a one-cycle increment pulse.

A small control state machine chooses the active path. It has five states. ST_OFF is the disabled state. ST_DIVIDE is time counting with the divider. ST_CLK_PASS is time counting with the divider bypassed. ST_FILTER is pulse counting with the glitch filter. ST_EDGE_PASS is pulse counting with the filter bypassed. The transition "arm" leaves ST_OFF on the first clock edge that samples the run input high, and it picks the working state from the mode and bypass inputs seen at that edge. The transition "disarm" returns any working state to ST_OFF on any edge that samples run low. No other transition exists, so mode and bypass changes made while running have no effect. Divider and filter state are cleared while in ST_OFF, and the filter takes the present pin level as its baseline.

The configuration word has this layout: bits 1:0 select the clock-enable source, bit 2 is bypass, and the bits above are the scale value p.

Top module: `tick_source`

## Requirements
- R1: After reset, inc_pulse is low and stays low until the block is enabled.
- R2: Bits 1:0 of scale_cfg select which src_stb bit is used. Bit 2 is bypass. Bits from 3 upward hold the scale value p. Strobes on unselected sources have no effect.
- R3: The first edge that samples run_en high only arms the block. Every later edge with run_en high is processed. On an edge that samples run_en low, the divider and filter are cleared and inc_pulse is low in the following cycle. A re-enabled divider therefore restarts a full period.
- R4: In time mode with bypass clear, one inc_pulse is produced for every 2^(p+1) selected strobes. It is high in the cycle after the edge that samples the last strobe of the group.
- R5: In time mode with bypass set, every selected strobe sampled at an edge gives inc_pulse high in the following cycle.
- R6: In pulse mode, pin_sel picks one of the pins, and the other pins have no effect. Each pin passes through a two-flop synchroniser. With pin_inv=0 the active level is high and rising edges count. With pin_inv=1 the active level is low and falling edges count.
- R7: In pulse mode with bypass set, each active edge of the selected synchronised pin gives exactly one inc_pulse, three cycles after the edge that first samples the pin change.
- R8: In pulse mode with bypass clear, a level change is accepted only after the synchronised level has differed from the accepted level on 2^p consecutive selected strobes, or on one strobe when p=0. A change that reverts earlier restarts the count. Only an accepted change to the active level produces an inc_pulse.
- R9: Mode and bypass are captured when the block arms. Changing them while running has no effect until the next re-enable.
- R10: Each counted event gives inc_pulse for exactly one cycle. In divided time mode, two inc_pulse cycles are never adjacent.
- R11: When the block arms, the pulse path takes the current pin level as its baseline, so a pin that is already active at enable does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer enable; low clears the divider and filter |
| pulse_mode | input | 1 | 0 time counting, 1 pulse counting |
| pin_sel | input | PIN_W | Pulse pin select |
| pin_inv | input | 1 | Pin polarity (1 = active low) |
| scale_cfg | input | SRC_W+1+SCALE_W | Source select, bypass, scale value |
| src_stb | input | NUM_SRC | Clock-enable strobes, one per source |
| pin_in | input | NUM_PIN | Asynchronous pulse pins |
| inc_pulse | output | 1 | One-cycle counter increment enable |

## Verification
The bench builds the block with SCALE_W=3, keeping four sources and four pins. This makes the largest scale value, 7, quick to reach. The full divide-by-256 period and the 128-strobe filter length at the top of the range are then exercised next to the p=0 cases (divide by 2 and single-strobe filter), so the width handling of the divider limit and the filter length is tested at both ends. A behavioural model predicts inc_pulse on every cycle across arming, disarming, mode capture and polarity. Separate event counts confirm the division ratios, glitch rejection and the ignored sources and pins.

// File: rtl/tick_pkg.sv
package tick_pkg;

    // Working state of the count-tick source
    typedef enum logic [2:0] {
        ST_OFF,
        ST_DIVIDE,
        ST_CLK_PASS,
        ST_FILTER,
        ST_EDGE_PASS
    } tick_state_e;

    // One enable per datapath, derived from the state
    typedef struct packed {
        logic divide;
        logic clk_pass;
        logic filter;
        logic edge_pass;
    } tick_path_t;

endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
    import tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       pulse_mode,
    input  logic       bypass,
    output tick_path_t path
);

    tick_state_e state_q;
    tick_state_e state_d;

    // Next-state logic: arm from ST_OFF, disarm from any working state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_en) begin
                    if (pulse_mode)
                        state_d = bypass ? ST_EDGE_PASS : ST_FILTER;
                    else
                        state_d = bypass ? ST_CLK_PASS : ST_DIVIDE;
                end
            end
            ST_DIVIDE, ST_CLK_PASS, ST_FILTER, ST_EDGE_PASS: begin
                if (!run_en)
                    state_d = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // Output decode: a path is live only while run_en is still high
    always_comb begin
        path = '0;
        unique case (state_q)
            ST_OFF:       path = '0;
            ST_DIVIDE:    path.divide    = run_en;
            ST_CLK_PASS:  path.clk_pass  = run_en;
            ST_FILTER:    path.filter    = run_en;
            ST_EDGE_PASS: path.edge_pass = run_en;
        endcase
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && run_en) |=> (state_q == $past(state_q)));

    // R3
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == ST_OFF));

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int SCALE_W = 4,
    parameter int DIV_W   = 2 ** SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               strobe,
    input  logic [SCALE_W-1:0] scale,
    output logic               fire
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W:0]   limit_wide;
    logic [DIV_W-1:0] limit;

    // Terminal count 2^(p+1)-1; the top scale value wraps to all ones
    always_comb begin
        limit_wide = ({{DIV_W{1'b0}}, 1'b1} << (32'(scale) + 32'd1)) - 1'b1;
        limit      = limit_wide[DIV_W-1:0];
    end

    assign fire = active && strobe && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active)
            cnt_q <= '0;
        else if (strobe)
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end

    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $stable(scale)) |-> (cnt_q <= limit));

    // R10
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/tick_pin_filter.sv
module tick_pin_filter #(
    parameter int NUM_PIN     = 4,
    parameter int PIN_W       = 2,
    parameter int SCALE_W     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 2 ** SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PIN-1:0] pin_in,
    input  logic [PIN_W-1:0]   pin_sel,
    input  logic               pin_inv,
    input  logic               strobe,
    input  logic [SCALE_W-1:0] scale,
    input  logic               filter_on,
    input  logic               pass_on,
    output logic               edge_ev
);

    logic [NUM_PIN-1:0] sync_lvl;

    // Per-pin synchroniser chains
    for (genvar g = 0; g < NUM_PIN; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sh_q <= '0;
            else
                sh_q <= {sh_q[SYNC_STAGES-2:0], pin_in[g]};
        end
        assign sync_lvl[g] = sh_q[SYNC_STAGES-1];
    end

    logic             lvl;
    logic             acc_q;
    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   len_w;
    logic [CNT_W:0]   cnt_nxt;
    logic             reach;

    assign lvl = sync_lvl[pin_sel] ^ pin_inv;

    // Qualification length 2^p, one strobe when p is zero
    always_comb begin
        if (scale == '0)
            len_w = {{CNT_W{1'b0}}, 1'b1};
        else
            len_w = {{CNT_W{1'b0}}, 1'b1} << scale;
        cnt_nxt = {1'b0, cnt_q} + 1'b1;
        reach   = (cnt_nxt >= len_w);
    end

    always_comb begin
        edge_ev = 1'b0;
        if (pass_on)
            edge_ev = lvl && !prev_q;
        else if (filter_on)
            edge_ev = lvl && !acc_q && strobe && reach;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= 1'b0;
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else if (pass_on) begin
            prev_q <= lvl;
        end else if (filter_on) begin
            if (lvl == acc_q) begin
                cnt_q <= '0;
            end else if (strobe) begin
                if (reach) begin
                    acc_q <= lvl;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_nxt[CNT_W-1:0];
                end
            end
        end else begin
            // idle or time mode: follow the pin as the baseline
            acc_q  <= lvl;
            prev_q <= lvl;
            cnt_q  <= '0;
        end
    end

    // R8
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_on && !strobe) |=> $stable(acc_q));

    // R10
    pass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_on && edge_ev) |=> !edge_ev);

endmodule

// File: rtl/tick_source.sv
module tick_source
    import tick_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int NUM_PIN     = 4,
    parameter int SCALE_W     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SRC_W      = $clog2(NUM_SRC),
    localparam int PIN_W      = $clog2(NUM_PIN),
    localparam int CFG_W      = SRC_W + 1 + SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               pulse_mode,
    input  logic [PIN_W-1:0]   pin_sel,
    input  logic               pin_inv,
    input  logic [CFG_W-1:0]   scale_cfg,
    input  logic [NUM_SRC-1:0] src_stb,
    input  logic [NUM_PIN-1:0] pin_in,
    output logic               inc_pulse
);

    localparam int DIV_W = 2 ** SCALE_W;

    logic [SRC_W-1:0]   src_sel;
    logic               bypass;
    logic [SCALE_W-1:0] scale;
    logic               strobe_sel;
    tick_path_t         path;
    logic               div_fire;
    logic               pin_ev;
    logic               inc_q;

    assign src_sel    = scale_cfg[SRC_W-1:0];
    assign bypass     = scale_cfg[SRC_W];
    assign scale      = scale_cfg[CFG_W-1:SRC_W+1];
    assign strobe_sel = src_stb[src_sel];

    tick_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .pulse_mode (pulse_mode),
        .bypass     (bypass),
        .path       (path)
    );

    tick_divider #(
        .SCALE_W (SCALE_W),
        .DIV_W   (DIV_W)
    ) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (path.divide),
        .strobe (strobe_sel),
        .scale  (scale),
        .fire   (div_fire)
    );

    tick_pin_filter #(
        .NUM_PIN     (NUM_PIN),
        .PIN_W       (PIN_W),
        .SCALE_W     (SCALE_W),
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (DIV_W)
    ) i_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .pin_sel   (pin_sel),
        .pin_inv   (pin_inv),
        .strobe    (strobe_sel),
        .scale     (scale),
        .filter_on (path.filter),
        .pass_on   (path.edge_pass),
        .edge_ev   (pin_ev)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            inc_q <= 1'b0;
        else
            inc_q <= div_fire | (path.clk_pass & strobe_sel) | pin_ev;
    end

    assign inc_pulse = inc_q;

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !inc_pulse);

    // R5
    pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path.clk_pass && strobe_sel) |=> inc_pulse);

    // R2
    src_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path.clk_pass && !strobe_sel) |=> !inc_pulse);

endmodule

// File: tb/test_tick_source.sv
`timescale 1ns/1ps
module test_tick_source;

    localparam int SW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       pulse_mode = 1'b0;
    logic [1:0] pin_sel = 2'd0;
    logic       pin_inv = 1'b0;
    logic [5:0] scale_cfg = 6'd0;
    logic [3:0] src_stb = 4'd0;
    logic [3:0] pin_in = 4'd0;
    logic       inc_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int inc_total = 0;
    int run_len  = 0;
    int max_run  = 0;

    always #2.5 clk = ~clk;

    tick_source #(.SCALE_W(SW)) i_tick_source (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pulse_mode(pulse_mode),
        .pin_sel(pin_sel), .pin_inv(pin_inv), .scale_cfg(scale_cfg),
        .src_stb(src_stb), .pin_in(pin_in), .inc_pulse(inc_pulse)
    );

    // ---------------- behavioural reference model ----------------
    logic [3:0] m_s1, m_s2;
    bit   m_inc = 0, m_armed, m_mode, m_byp, m_acc, m_prev;
    int   m_div, m_cnt, mp, mlen;
    bit   m_stb, m_lvl, m_act, m_ev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_inc = 0; m_div = 0; m_cnt = 0;
            m_acc = 0; m_prev = 0; m_armed = 0; m_mode = 0; m_byp = 0;
        end else begin
            mp    = int'(scale_cfg[5:3]);
            mlen  = (mp == 0) ? 1 : (1 << mp);
            m_stb = src_stb[scale_cfg[1:0]];
            m_lvl = m_s2[pin_sel] ^ pin_inv;
            m_act = m_armed && run_en;
            m_ev  = 0;
            if (!m_act) begin
                m_div = 0; m_cnt = 0; m_acc = m_lvl; m_prev = m_lvl;
            end else if (!m_mode) begin
                if (m_stb) begin
                    if (m_byp) m_ev = 1;
                    else if (m_div == (1 << (mp + 1)) - 1) begin m_div = 0; m_ev = 1; end
                    else m_div++;
                end
            end else if (m_byp) begin
                m_ev = m_lvl && !m_prev;
                m_prev = m_lvl;
            end else begin
                if (m_lvl == m_acc) m_cnt = 0;
                else if (m_stb) begin
                    if (m_cnt + 1 >= mlen) begin m_acc = m_lvl; m_cnt = 0; m_ev = m_lvl; end
                    else m_cnt++;
                end
            end
            if (!m_armed && run_en) begin m_mode = pulse_mode; m_byp = scale_cfg[2]; end
            m_armed = run_en;
            m_inc = m_ev;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    // event counting and pulse width tracking
    always @(posedge clk) begin
        if (inc_pulse) begin
            inc_total++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (inc_pulse !== m_inc) begin
                n_fail++;
                $display("FAIL %s cycle compare at %0t: actual=%0b expected=%0b",
                         !m_armed ? "R3" : (m_mode ? (m_byp ? "R7" : "R8") : (m_byp ? "R5" : "R4")),
                         $time, inc_pulse, m_inc);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int src, input bit byp, input int p);
        scale_cfg = {3'(p), byp, 2'(src)};
    endtask

    task automatic arm();
        run_en = 1'b1;
        tick(1);
    endtask

    task automatic disarm();
        src_stb = 4'd0;
        run_en  = 1'b0;
        tick(3);
    endtask

    int c0;

    initial begin
        #200000;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check(inc_pulse == 1'b0, "R1 reset output", int'(inc_pulse), 0);
        c0 = inc_total;
        for (int i = 0; i < 10; i++) begin src_stb = 4'hF; tick(1); end
        src_stb = 0; tick(2);
        check(inc_total - c0 == 0, "R3 disabled quiet", inc_total - c0, 0);

        // R4 divide by 8, source 1, other sources toggling
        pulse_mode = 0; set_cfg(1, 0, 2); tick(1);
        arm(); c0 = inc_total; max_run = 0;
        for (int i = 0; i < 64; i++) begin src_stb = {i[0], 1'b0, 1'b1, i[1]}; tick(1); end
        src_stb = 0; tick(3);
        check(inc_total - c0 == 8, "R4 divide by 8", inc_total - c0, 8);
        check(max_run == 1, "R10 single-cycle pulse", max_run, 1);
        disarm();

        // R4 / R2 divide by 2 on source 2
        set_cfg(2, 0, 0); arm(); c0 = inc_total;
        for (int i = 0; i < 40; i++) begin
            src_stb = 4'b0100; tick(1);
            src_stb = 4'b1011; tick(1);
        end
        src_stb = 0; tick(3);
        check(inc_total - c0 == 20, "R2 R4 divide by 2 on source 2", inc_total - c0, 20);
        disarm();

        // R4 top scale: divide by 256
        set_cfg(3, 0, 7); arm(); c0 = inc_total;
        for (int i = 0; i < 600; i++) begin src_stb = 4'b1000; tick(1); end
        src_stb = 0; tick(3);
        check(inc_total - c0 == 2, "R4 divide by 256", inc_total - c0, 2);
        disarm();

        // R5 bypass
        set_cfg(0, 1, 5); arm(); c0 = inc_total;
        for (int i = 0; i < 30; i++) begin
            src_stb = 4'b0001; tick(1);
            src_stb = 4'b1110; tick(2);
        end
        src_stb = 0; tick(3);
        check(inc_total - c0 == 30, "R5 clock bypass", inc_total - c0, 30);
        disarm();

        // R3 restart after disable
        set_cfg(1, 0, 2); arm(); c0 = inc_total;
        for (int i = 0; i < 6; i++) begin src_stb = 4'b0010; tick(1); end
        disarm(); arm();
        for (int i = 0; i < 4; i++) begin src_stb = 4'b0010; tick(1); end
        src_stb = 0; tick(3);
        check(inc_total - c0 == 0, "R3 divider cleared on disable", inc_total - c0, 0);
        for (int i = 0; i < 4; i++) begin src_stb = 4'b0010; tick(1); end
        src_stb = 0; tick(3);
        check(inc_total - c0 == 1, "R3 full period after enable", inc_total - c0, 1);
        disarm();

        // R7 pulse bypass on pin 2, other pins toggling
        pulse_mode = 1; set_cfg(0, 1, 0); pin_sel = 2; pin_inv = 0; pin_in = 0; tick(3);
        arm(); c0 = inc_total;
        for (int i = 0; i < 10; i++) begin
            pin_in[2] = 1; pin_in[0] = ~pin_in[0]; tick(3);
            pin_in[2] = 0; pin_in[3] = ~pin_in[3]; tick(3);
        end
        tick(4);
        check(inc_total - c0 == 10, "R7 edge bypass count", inc_total - c0, 10);
        c0 = inc_total;
        for (int i = 0; i < 20; i++) begin pin_in[1:0] = 2'(i); pin_in[3] = i[0]; tick(2); end
        tick(4);
        check(inc_total - c0 == 0, "R6 unselected pins ignored", inc_total - c0, 0);
        disarm();

        // R6 / R11 inverted polarity, pin idle low is already active
        pin_in = 0; pin_inv = 1; tick(3);
        arm(); c0 = inc_total;
        pin_in[2] = 1; tick(6);
        check(inc_total - c0 == 0, "R6 R11 rising ignored when inverted", inc_total - c0, 0);
        pin_in[2] = 0; tick(6);
        check(inc_total - c0 == 1, "R6 falling counted when inverted", inc_total - c0, 1);
        disarm();

        // R8 filter p=2, strobe every cycle on source 0
        pin_inv = 0; pin_in = 0; pin_sel = 1; set_cfg(0, 0, 2); src_stb = 4'b0001; tick(3);
        run_en = 1; tick(1); c0 = inc_total;
        for (int i = 0; i < 5; i++) begin pin_in[1] = 1; tick(2); pin_in[1] = 0; tick(6); end
        check(inc_total - c0 == 0, "R8 glitches rejected", inc_total - c0, 0);
        for (int i = 0; i < 5; i++) begin pin_in[1] = 1; tick(10); pin_in[1] = 0; tick(10); end
        check(inc_total - c0 == 5, "R8 stable pulses counted", inc_total - c0, 5);
        src_stb = 4'b0010; c0 = inc_total;
        pin_in[1] = 1; tick(12); pin_in[1] = 0; tick(12);
        check(inc_total - c0 == 0, "R8 no filter clock no acceptance", inc_total - c0, 0);
        disarm();

        // R8 p=0 single-strobe filter
        set_cfg(0, 0, 0); src_stb = 4'b0001; run_en = 1; tick(1); c0 = inc_total;
        for (int i = 0; i < 6; i++) begin pin_in[1] = 1; tick(1); pin_in[1] = 0; tick(4); end
        tick(4);
        check(inc_total - c0 == 6, "R8 zero scale filter", inc_total - c0, 6);
        disarm();

        // R8 top filter length 128
        set_cfg(0, 0, 7); src_stb = 4'b0001; run_en = 1; tick(1); c0 = inc_total;
        pin_in[1] = 1; tick(140); pin_in[1] = 0; tick(140);
        pin_in[1] = 1; tick(120); pin_in[1] = 0; tick(140);
        check(inc_total - c0 == 1, "R8 filter length 128", inc_total - c0, 1);
        disarm();

        // R9 mode captured at enable
        pulse_mode = 1; set_cfg(0, 1, 0); pin_in = 0; tick(3);
        arm(); pulse_mode = 0; c0 = inc_total;
        for (int i = 0; i < 20; i++) begin src_stb = 4'b0001; tick(1); end
        src_stb = 0; tick(3);
        check(inc_total - c0 == 0, "R9 mode change while running ignored", inc_total - c0, 0);
        disarm();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule